// File: doc/BRIEF.md
# Crystal Strap Capture with Delayed Sampling

This block reads a crystal-frequency selection from configuration pins that also serve as LED outputs once the chip is running. While reset is held, and afterwards until the sample is taken, it keeps the LED drivers off so that the external pull resistors can set the pins to their bootstrap levels. A counter started at reset release waits a set number of clock cycles. The pin levels then pass through a synchronizer and are latched into a read-only code. A decoded frequency, an error flag for the reserved code and a ready indication all come from that latched code.

Two pin arrangements are available through a parameter. In the two-pin arrangement a 2-bit code selects 20, 40 or 25 MHz, and one code value is reserved. In the one-pin arrangement a high level selects 25 MHz and a low level selects 40 MHz. The latched value stays fixed until reset is asserted again, and the LED output enable turns on at the capture edge.

Top module: `xtal_strap_capture`

## Requirements
- R1: While reset is asserted, and at every edge after release up to the capture edge, strap_code is 0, freq_sel is 0, strap_err is 0, strap_ready is 0 and led_oe is 0.
- R2: Capture takes place on exactly the DELAY_CYCLES-th rising clock edge after reset release. led_oe is 0 after edge DELAY_CYCLES-1 and 1 after edge DELAY_CYCLES.
- R3: The pins are synchronized through SYNC_STAGES flops (default 2). The captured value is the pin level sampled at edge DELAY_CYCLES-2 after release. Pin changes after that edge do not reach the latched code.
- R4: In the two-pin arrangement, with the code taken as {strap_pins[1], strap_pins[0]}: code 01 gives freq_sel 1 (20 MHz), code 10 gives freq_sel 2 (40 MHz) and code 11 gives freq_sel 3 (25 MHz). Each of these codes sets strap_ready to 1 and strap_err to 0.
- R5: A captured code of 00 is reserved. It gives strap_err 1, strap_ready 0 and freq_sel 0 (no frequency).
- R6: After capture, strap_code and the decoded outputs hold their values whatever the pins do, until reset is asserted again.
- R7: led_oe stays 0 until the capture edge and stays 1 from then until the next reset assertion.
- R8: In the one-pin arrangement (PIN_COUNT=1), a high level gives freq_sel 3 (25 MHz) and a low level gives freq_sel 2 (40 MHz). strap_err is never raised in this arrangement.
- R9: Asserting reset again after a capture clears all outputs at once, and a new capture follows the next release with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_pins | input | PIN_COUNT | Raw levels of the shared strap/LED pins |
| strap_code | output | PIN_COUNT | Latched strap code, 0 before capture |
| freq_sel | output | 2 | Decoded frequency: 0 none, 1 20 MHz, 2 40 MHz, 3 25 MHz |
| strap_err | output | 1 | The captured code is the reserved value |
| strap_ready | output | 1 | A valid frequency has been captured |
| led_oe | output | 1 | Allows the LED drivers onto the pins |

## Verification
The hardest case to reach from the ports is a pin edge that falls inside the synchronizer window just before capture. In that case the latched value must be the level from two edges earlier, not the level present at the capture edge. To create it, the stimulus tracks the edge count since reset release and changes the pins on the negative edge right after edge DELAY_CYCLES-2. The pins therefore carry a different value during the last two edges before capture. A cycle-by-cycle reference model records the pin level at the expected sampling edge and compares every output on every clock.

// File: rtl/xtal_strap_pkg.sv
package xtal_strap_pkg;
   typedef enum logic [1:0] {
      FQ_NONE = 2'd0,
      FQ_20M  = 2'd1,
      FQ_40M  = 2'd2,
      FQ_25M  = 2'd3
   } freq_e;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/strap_timer.sv
module strap_timer #(
   parameter int DELAY_CYCLES = 62400
) (
   input  logic clk,
   input  logic rst_n,
   output logic fire_o,
   output logic done_o
);
   localparam int CW = $clog2(DELAY_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          done_q;

   assign fire_o = !done_q && (cnt_q == LAST);
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (fire_o) done_q <= 1'b1;
         else        cnt_q  <= cnt_q + 1'b1;
      end
   end

   assert_fire_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> (done_q && !fire_o));
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> (cnt_q <= LAST));
endmodule

// File: rtl/strap_decode.sv
module strap_decode
   import xtal_strap_pkg::*;
#(
   parameter int PIN_COUNT = 2
) (
   input  logic                 valid_i,
   input  logic [PIN_COUNT-1:0] code_i,
   output freq_e                freq_o,
   output logic                 err_o
);
   if (PIN_COUNT == 2) begin : g_two_pin
      always_comb begin
         freq_o = FQ_NONE;
         err_o  = 1'b0;
         if (valid_i) begin
            unique case (code_i)
               2'b01:   freq_o = FQ_20M;
               2'b10:   freq_o = FQ_40M;
               2'b11:   freq_o = FQ_25M;
               default: err_o  = 1'b1;
            endcase
         end
      end
   end else begin : g_one_pin
      always_comb begin
         err_o  = 1'b0;
         freq_o = FQ_NONE;
         if (valid_i) freq_o = code_i[0] ? FQ_25M : FQ_40M;
      end
   end
endmodule

// File: rtl/xtal_strap_capture.sv
module xtal_strap_capture
   import xtal_strap_pkg::*;
#(
   parameter int PIN_COUNT    = 2,
   parameter int SYNC_STAGES  = 2,
   parameter int DELAY_CYCLES = 62400
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PIN_COUNT-1:0] strap_pins,
   output logic [PIN_COUNT-1:0] strap_code,
   output logic [1:0]           freq_sel,
   output logic                 strap_err,
   output logic                 strap_ready,
   output logic                 led_oe
);
   if (PIN_COUNT != 1 && PIN_COUNT != 2) begin : g_bad_pins
      $error("PIN_COUNT must be 1 or 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DELAY_CYCLES < SYNC_STAGES + 1) begin : g_bad_delay
      $error("DELAY_CYCLES must exceed SYNC_STAGES");
   end

   logic [PIN_COUNT-1:0] pins_sync;
   logic                 fire, done;
   logic [PIN_COUNT-1:0] code_q;
   logic                 oe_q;
   freq_e                freq;
   logic                 err;

   strap_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(strap_pins), .q_o(pins_sync));

   strap_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .fire_o(fire), .done_o(done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         oe_q   <= 1'b0;
      end else if (fire) begin
         code_q <= pins_sync;
         oe_q   <= 1'b1;
      end
   end

   strap_decode #(.PIN_COUNT(PIN_COUNT)) u_dec (
      .valid_i(done), .code_i(code_q), .freq_o(freq), .err_o(err));

   assign strap_code  = code_q;
   assign freq_sel    = freq;
   assign strap_err   = err;
   assign strap_ready = done && !err;
   assign led_oe      = oe_q;

   assert_hold_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oe_q) |-> $stable(code_q));
   assert_err_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      strap_err |-> (!strap_ready && freq_sel == 2'd0));
   assert_quiet_before_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_q |-> (code_q == '0 && !strap_ready && !strap_err));
   assert_oe_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oe_q) |-> oe_q);
   assert_ready_freq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      strap_ready |-> (freq_sel != 2'd0));
endmodule

// File: tb/sim_xtal_strap_capture.sv
`timescale 1ns/1ps
module sim_xtal_strap_capture;
   localparam int DLY = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pins = 2'b00;
   logic [0:0] pin_s = 1'b0;
   logic [1:0] code0, freq0, freq1;
   logic [0:0] code1;
   logic       err0, rdy0, oe0, err1, rdy1, oe1;

   int n_checks = 0;
   int n_errors = 0;
   bit chk_on = 0;

   always #2.5 clk = ~clk;

   xtal_strap_capture #(.PIN_COUNT(2), .SYNC_STAGES(2), .DELAY_CYCLES(DLY)) u0 (
      .clk(clk), .rst_n(rst_n), .strap_pins(pins), .strap_code(code0),
      .freq_sel(freq0), .strap_err(err0), .strap_ready(rdy0), .led_oe(oe0));

   xtal_strap_capture #(.PIN_COUNT(1), .SYNC_STAGES(2), .DELAY_CYCLES(DLY)) u1 (
      .clk(clk), .rst_n(rst_n), .strap_pins(pin_s), .strap_code(code1),
      .freq_sel(freq1), .strap_err(err1), .strap_ready(rdy1), .led_oe(oe1));

   // reference model: edge count since release, pin level recorded at edge DLY-2
   int         n = 0;
   logic       cap_m = 0;
   logic [1:0] code_m = 0;
   logic       c1_m = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         n = 0; cap_m = 0; code_m = 0; c1_m = 0;
      end else begin
         n = n + 1;
         if (n == DLY - 2) begin code_m = pins; c1_m = pin_s[0]; end
         if (n == DLY) cap_m = 1;
      end
   end

   task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         logic [6:0] a0, e0, a1, e1;
         logic [1:0] f1;
         string tag;
         tag = !cap_m ? "R1" : (code_m == 2'b00 ? "R5" : "R4");
         a0 = {code0, freq0, err0, rdy0, oe0};
         e0 = cap_m ? {code_m, code_m, code_m == 2'b00, code_m != 2'b00, 1'b1} : 7'd0;
         check(a0 == e0, tag, {1'b0, a0}, {1'b0, e0});
         f1 = c1_m ? 2'd3 : 2'd2;
         a1 = {1'b0, code1, freq1, err1, rdy1, oe1};
         e1 = cap_m ? {1'b0, c1_m, f1, 1'b0, 1'b1, 1'b1} : 7'd0;
         check(a1 == e1, "R8", {1'b0, a1}, {1'b0, e1});
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic do_reset(input logic [1:0] p, input logic s);
      step();
      rst_n = 1'b0;
      pins = p;
      pin_s = s;
      step();
      check(oe0 == 0 && code0 == 0 && rdy0 == 0, "R9",
            {3'b0, code0, rdy0, oe0}, 8'h00);
      step();
      step();
      rst_n = 1'b1;
   endtask

   task automatic run_to(input int target);
      while (n != target) step();
   endtask

   initial begin
      #(200000 * 5);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      step();
      check(oe0 == 0 && code0 == 0 && err0 == 0, "R1", {5'b0, oe0, err0, rdy0}, 8'h00);
      chk_on = 1;

      // R2 / R4: 40 MHz, timing of capture edge
      do_reset(2'b10, 1'b1);
      run_to(DLY - 1);
      check(oe0 == 1'b0, "R2", {7'b0, oe0}, 8'h00);
      step();
      check(oe0 == 1'b1 && freq0 == 2'd2, "R2", {5'b0, oe0, freq0}, 8'h06);

      // R6: pin activity after capture is ignored
      pins = 2'b01; pin_s = 1'b0;
      repeat (6) step();
      check(code0 == 2'b10 && freq1 == 2'd3, "R6", {4'b0, code0, freq1}, 8'h0b);
      check(oe0 == 1'b1, "R7", {7'b0, oe0}, 8'h01);

      // R9 / R4: new capture after reset re-assertion, 20 MHz
      do_reset(2'b01, 1'b0);
      run_to(DLY + 1);
      check(freq0 == 2'd1 && rdy0, "R9", {5'b0, rdy0, freq0}, 8'h05);
      check(freq1 == 2'd2, "R8", {6'b0, freq1}, 8'h02);

      // R4: 25 MHz
      do_reset(2'b11, 1'b1);
      run_to(DLY + 2);
      check(freq0 == 2'd3, "R4", {6'b0, freq0}, 8'h03);

      // R5: reserved code
      do_reset(2'b00, 1'b0);
      run_to(DLY + 2);
      check(err0 && !rdy0 && freq0 == 0, "R5", {5'b0, err0, rdy0, oe0}, 8'h05);

      // R3: pin edge inside the synchronizer window
      do_reset(2'b11, 1'b0);
      run_to(DLY - 3);
      pins = 2'b01;
      step();
      pins = 2'b10;
      run_to(DLY + 2);
      check(code0 == 2'b01, "R3", {6'b0, code0}, 8'h01);

      repeat (4) step();
      chk_on = 0;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule